// File: doc/BRIEF.md
# Product-Term Logic Block with Shared and Chained Expanders

This block is a configurable sum-of-products array. Sixteen cells each own five AND terms built over a 36-bit input bus. Each term can also use the inverted "expander" outputs that cells donate to a common pool. A routing word per cell decides which terms go into the cell's OR sum and which drive the cell's four register-control outputs (clear, preset, clock, enable). An XOR polarity stage follows the OR.

Terms can also be lent upward in two independent chains of eight cells, so a wide function can gather up to fifteen extra terms from its lower neighbours. The logic path is purely combinational. The configuration lives in registers that are written through two simple write ports: one for term literal masks and one for per-cell routing words. The registers that the control outputs would drive are outside this block.

Top module: `pterm_lab`

## Requirements
- R1: An active-low asynchronous reset clears every mask and routing word, so that all outputs and the error flag read 0.
- R2: A term mask uses bit i in [51:0] to require array input i to be true, and bit 52+i to require it to be false. Array inputs 0..35 are the direct inputs and 36+k is expander k. A term with no literal set, or with both literals of one input set, evaluates to 0.
- R3: A cell's output is the OR of the terms flagged in routing bits [4:0], XORed with the polarity bit [16].
- R4: The control selects are clear [19:17], preset [22:20], clock [25:23] and enable [28:26]. A value v in 1..5 drives that output from term v-1. A value of 0 or a value above 5 drives 0.
- R5: Bit [10] enables cell k's expander and bits [13:11] pick the donated term (0..4). Expander k reads as the inverse of that term, evaluated over the direct inputs only. When the expander is disabled or the selection is invalid, it reads 1.
- R6: Depth bits [15:14] (0..3) make a cell OR in the lent terms of the cells 1..depth below it in the same chain of eight.
- R7: Lend bits [9:5] mark terms as lent. A lent term leaves its own cell's sum.
- R8: The chains are cells 0-7 and 8-15, and no borrowing crosses the boundary. The lend bits of the top cell of each chain have no effect.
- R9: The error flag is high when a cell both sums and effectively lends the same term, or when a lender with lent terms is claimed by more than one borrower.
- R10: Outputs follow the inputs and the configuration combinationally. A configuration write takes effect from the clock edge on which it is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration write clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lin | input | 36 | Direct array inputs |
| mask_we | input | 1 | Term mask write strobe |
| mask_addr | input | 7 | Term index, cell*5+term |
| mask_data | input | 104 | Term literal mask |
| cell_we | input | 1 | Routing word write strobe |
| cell_addr | input | 4 | Cell index |
| cell_data | input | 29 | Routing word |
| mc_out | output | 16 | Cell outputs after polarity |
| ctl_clr | output | 16 | Clear control term per cell |
| ctl_pre | output | 16 | Preset control term per cell |
| ctl_clk | output | 16 | Clock control term per cell |
| ctl_ena | output | 16 | Enable control term per cell |
| cfg_err | output | 1 | Configuration conflict flag |

## Verification
The assertions assume that the direct inputs change only between clock edges. The output-stability and polarity-flip properties compare samples on successive edges, and they would be ambiguous if an input moved at an edge. The bench drives every input and every write strobe on the falling edge, so the properties see a settled value. It also never raises both write strobes in the same cycle when it toggles a polarity bit. Conflicting configurations are entered only on purpose, for the error-flag checks, and are cleared before later tests.

// File: rtl/pterm_lab.sv
module pterm_lab #(
  parameter int NCELL = 16,
  parameter int NIN   = 36,
  parameter int NPT   = 5,
  parameter int GRP   = 8,
  parameter int MAXD  = 3
)(
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic [NIN-1:0]                         lin,
  input  logic                                   mask_we,
  input  logic [$clog2(NCELL*NPT)-1:0]           mask_addr,
  input  logic [2*(NIN+NCELL)-1:0]               mask_data,
  input  logic                                   cell_we,
  input  logic [$clog2(NCELL)-1:0]               cell_addr,
  input  logic [2*NPT+2+$clog2(NPT)+$clog2(MAXD+1)+4*$clog2(NPT+1)-1:0] cell_data,
  output logic [NCELL-1:0]                       mc_out,
  output logic [NCELL-1:0]                       ctl_clr,
  output logic [NCELL-1:0]                       ctl_pre,
  output logic [NCELL-1:0]                       ctl_clk,
  output logic [NCELL-1:0]                       ctl_ena,
  output logic                                   cfg_err
);
  localparam int NA     = NIN + NCELL;
  localparam int MW     = 2 * NA;
  localparam int NTERM  = NCELL * NPT;
  localparam int SSW    = $clog2(NPT);
  localparam int DW     = $clog2(MAXD + 1);
  localparam int SELW   = $clog2(NPT + 1);
  localparam int O_LEND = NPT;
  localparam int O_SHE  = 2 * NPT;
  localparam int O_SHS  = O_SHE + 1;
  localparam int O_DEP  = O_SHS + SSW;
  localparam int O_POL  = O_DEP + DW;
  localparam int O_CTL  = O_POL + 1;
  localparam int CW     = O_CTL + 4 * SELW;
  localparam logic [CW-1:0] POLMASK = CW'(1) << O_POL;

  logic [MW-1:0]  mask_q [NTERM];
  logic [CW-1:0]  cell_q [NCELL];
  logic [NCELL-1:0] shx, par;
  logic [NPT-1:0] lend_e [NCELL];
  logic [NPT-1:0] sum_e  [NCELL];
  logic [DW-1:0]  dep    [NCELL];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NTERM; k++) mask_q[k] <= '0;
      for (int k = 0; k < NCELL; k++) cell_q[k] <= '0;
    end else begin
      if (mask_we && 32'(mask_addr) < NTERM) mask_q[mask_addr] <= mask_data;
      if (cell_we && 32'(cell_addr) < NCELL) cell_q[cell_addr] <= cell_data;
    end
  end

  function automatic logic pick(input logic [NPT-1:0] v, input logic [SELW-1:0] s);
    pick = 1'b0;
    for (int k = 0; k < NPT; k++) if (32'(s) == k + 1) pick = v[k];
  endfunction

  for (genvar c = 0; c < NCELL; c++) begin : g_cell
    logic [CW-1:0]  w;
    logic [NPT-1:0] ptd, ptf;
    logic [MAXD:1]  take;

    assign w         = cell_q[c];
    assign sum_e[c]  = w[NPT-1:0];
    assign lend_e[c] = (c % GRP == GRP - 1) ? '0 : w[O_LEND +: NPT];
    assign dep[c]    = w[O_DEP +: DW];

    for (genvar t = 0; t < NPT; t++) begin : g_term
      logic [NA-1:0] tv, cv;
      assign tv = mask_q[c*NPT+t][NA-1:0];
      assign cv = mask_q[c*NPT+t][MW-1:NA];
      assign ptd[t] = (|mask_q[c*NPT+t]) & (&(~tv[NIN-1:0] | lin)) & (&(~cv[NIN-1:0] | ~lin));
      assign ptf[t] = ptd[t] & (&(~tv[NA-1:NIN] | shx)) & (&(~cv[NA-1:NIN] | ~shx));
    end

    assign shx[c] = ~(w[O_SHE] & pick(ptd, SELW'(w[O_SHS +: SSW]) + SELW'(1)));
    assign par[c] = |(ptf & lend_e[c]);

    for (genvar d = 1; d <= MAXD; d++) begin : g_brw
      if ((c % GRP) >= d) begin : g_ok
        assign take[d] = (32'(dep[c]) >= d) & par[c-d];
      end else begin : g_no
        assign take[d] = 1'b0;
      end
    end

    assign mc_out[c]  = ((|(ptf & sum_e[c] & ~lend_e[c])) | (|take)) ^ w[O_POL];
    assign ctl_clr[c] = pick(ptf, w[O_CTL +: SELW]);
    assign ctl_pre[c] = pick(ptf, w[O_CTL + SELW +: SELW]);
    assign ctl_clk[c] = pick(ptf, w[O_CTL + 2*SELW +: SELW]);
    assign ctl_ena[c] = pick(ptf, w[O_CTL + 3*SELW +: SELW]);

    assert_ctl_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (w[O_CTL +: SELW] == '0) |-> !ctl_clr[c]);
    assert_overlap_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (|(sum_e[c] & lend_e[c])) |-> cfg_err);
  end

  always_comb begin
    int n;
    cfg_err = 1'b0;
    for (int j = 0; j < NCELL; j++) begin
      n = 0;
      for (int c = j + 1; c < NCELL; c++)
        if ((c / GRP) == (j / GRP) && (c - j) <= int'(dep[c]) && (|lend_e[j])) n++;
      if (n > 1 || (|(sum_e[j] & lend_e[j]))) cfg_err = 1'b1;
    end
  end

  assert_clean_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (mc_out == '0 && !cfg_err));
  assert_comb_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(mask_we) && !$past(cell_we) && $stable(lin)) |-> $stable(mc_out));
  assert_pol_flip_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_we && !mask_we && cell_data == (cell_q[cell_addr] ^ POLMASK))
    |=> ($stable(lin) -> (mc_out[$past(cell_addr)] != $past(mc_out[cell_addr]))));
endmodule

// File: tb/test_pterm_lab.sv
module test_pterm_lab;
  timeunit 1ns; timeprecision 100ps;

  logic clk = 0, rst_n = 0;
  logic [35:0] lin = '0;
  logic mask_we = 0, cell_we = 0;
  logic [6:0] mask_addr = '0;
  logic [103:0] mask_data = '0;
  logic [3:0] cell_addr = '0;
  logic [28:0] cell_data = '0;
  logic [15:0] mc_out, ctl_clr, ctl_pre, ctl_clk, ctl_ena;
  logic cfg_err;
  int tests = 0, failed = 0;
  bit done = 0;

  pterm_lab i_pterm_lab (.*);

  always #2.5 clk = ~clk;

  localparam logic [51:0] VEC [8] = '{
    {36'h000, 16'h0000}, {36'h1FF, 16'h0093}, {36'h003, 16'h0001}, {36'h014, 16'h0006},
    {36'h020, 16'h0010}, {36'h140, 16'h0090}, {36'h01C, 16'h0002}, {36'h100, 16'h0080}};

  function automatic logic [103:0] lt(int idx);  return 104'(1) << idx;        endfunction
  function automatic logic [103:0] lc(int idx);  return 104'(1) << (52 + idx); endfunction
  function automatic logic [28:0] cw(logic [4:0] s, logic [4:0] l = 0, logic se = 0,
      logic [2:0] ss = 0, logic [1:0] d = 0, logic p = 0, logic [2:0] cl = 0,
      logic [2:0] pr = 0, logic [2:0] ck = 0, logic [2:0] en = 0);
    return {en, ck, pr, cl, p, d, ss, se, l, s};
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wm(int a, logic [103:0] d);
    @(negedge clk); mask_we = 1; mask_addr = 7'(a); mask_data = d;
    @(negedge clk); mask_we = 0; #1;
  endtask

  task automatic wc(int a, logic [28:0] d);
    @(negedge clk); cell_we = 1; cell_addr = 4'(a); cell_data = d;
    @(negedge clk); cell_we = 0; #1;
  endtask

  task automatic drive(logic [35:0] v);
    @(negedge clk); lin = v; #1;
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      tests++; failed++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    #1;
    chk("R1 out", 64'(mc_out), 0);
    chk("R1 ctl", 64'({ctl_clr, ctl_pre, ctl_clk, ctl_ena}), 0);
    chk("R1 err", 64'(cfg_err), 0);
    @(negedge clk); rst_n = 1; #1;
    chk("R1 out after release", 64'(mc_out), 0);

    wm(0, lt(0) | lt(1));            wc(0, cw(5'b00001));
    wm(5, lc(2));                    wc(1, cw(5'b00001, .p(1)));
    wm(10, lt(3)); wm(11, lt(4) | lt(38));
    wc(2, cw(5'b00010, .se(1), .ss(0)));
    wm(15, lt(5));                   wc(3, cw(5'b0, .l(5'b00001)));
    wm(20, lt(6));                   wc(4, cw(5'b00001, .d(1)));
    wm(35, lt(8));                   wc(7, cw(5'b00001, .l(5'b00001)));
    wc(8, cw(5'b0, .d(3)));

    for (int i = 0; i < 8; i++) begin
      drive(VEC[i][51:16]);
      chk("R3 R6 R8 R10 table", 64'(mc_out), 64'(VEC[i][15:0]));
      chk("R8 R9 no err", 64'(cfg_err), 0);
    end

    wm(25, lt(45)); wc(5, cw(5'b00001));
    drive('0);
    chk("R5 disabled expander reads 1", 64'(mc_out[5]), 1);
    wm(30, lt(0) | lc(0)); wc(6, cw(5'b00001));
    drive(36'h1);
    chk("R2 contradictory term", 64'(mc_out[6]), 0);
    drive(36'h0);
    chk("R2 contradictory term low", 64'(mc_out[6]), 0);
    wm(10, lt(3) | lt(38));
    drive(36'h010);
    chk("R5 donated term ignores expander literal", 64'(mc_out[2]), 1);
    drive(36'h018);
    chk("R5 expander inverted", 64'(mc_out[2]), 0);

    drive(36'h004);
    chk("R3 pol set", 64'(mc_out[1]), 1);
    wc(1, cw(5'b00001, .p(0)));
    chk("R3 pol cleared", 64'(mc_out[1]), 0);

    wm(52, lt(10)); wc(10, cw(5'b0, .cl(3)));
    drive(36'h400);
    chk("R4 clear routed", 64'(ctl_clr), 64'h0400);
    chk("R4 preset idle", 64'(ctl_pre | ctl_clk | ctl_ena), 0);
    chk("R4 routed term not summed", 64'(mc_out[10]), 0);

    wm(55, lt(11)); wc(11, cw(5'b0, .l(1)));
    wm(60, lt(12)); wc(12, cw(5'b0, .l(1)));
    wm(65, lt(13)); wc(13, cw(5'b0, .l(1)));
    wc(14, cw(5'b0, .d(3)));
    drive(36'h1000);
    chk("R6 borrow depth2", 64'(mc_out[15:11]), 64'h08);
    drive(36'h0800);
    chk("R6 borrow depth3", 64'(mc_out[15:11]), 64'h08);
    chk("R9 single claims ok", 64'(cfg_err), 0);
    drive(36'h0);
    chk("R6 borrow none", 64'(mc_out[14]), 0);
    wc(14, cw(5'b0, .d(2)));
    drive(36'h0800);
    chk("R6 beyond depth", 64'(mc_out[14]), 0);
    wc(14, cw(5'b0, .d(3)));

    wc(13, cw(5'b00001, .l(1)));
    drive(36'h2000);
    chk("R7 lent term removed", 64'(mc_out[13]), 0);
    chk("R7 lent term reaches borrower", 64'(mc_out[14]), 1);
    chk("R9 use and lend", 64'(cfg_err), 1);
    wc(13, cw(5'b0, .l(1)));
    chk("R9 cleared", 64'(cfg_err), 0);

    wc(15, cw(5'b0, .d(2)));
    chk("R9 double claim", 64'(cfg_err), 1);
    wc(15, cw(5'b0));
    chk("R9 double claim cleared", 64'(cfg_err), 0);

    done = 1;
    summary();
  end
endmodule